// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block manages one 8-bit I/O port. A small synchronous register bus lets the CPU choose, pin by pin, whether a pin belongs to the general-purpose path or to an on-chip peripheral. It also lets the CPU set the direction, the driven value and a weak pull-up for each pin, and read back the live pin levels. For every pin the block produces an output value, an output enable, a pull-up enable and an input-buffer enable for a pad model. It also returns the synchronised pin levels to the peripheral.

A pin in general-purpose mode is driven from the direction and output-data registers. A pin handed to the peripheral takes its value and tri-state control from the peripheral. The pull-up is only applied to a released pin in general-purpose mode. An open-drain line is made by holding the output bit at 0 and switching the direction bit. The output-data register keeps its contents through reset. Pin levels pass through a two-flop synchroniser before they reach the CPU or the peripheral.

Top module: `gpio_mux_port`

## Requirements
- R1: A pin whose select bit (register offset 0x0) is 1 takes pad_out from per_out and pad_oe from per_oe. A pin whose bit is 0 is unaffected by the peripheral signals. Each bit acts independently.
- R2: A pin in GPIO mode has pad_oe equal to its direction bit (offset 0x2, 1 = drive) and pad_out equal to its output-data bit (offset 0x6).
- R3: pad_ie is always 1 for peripheral pins. For GPIO pins it is 1 only while bus_rd is high with bus_addr = 0x4, and 0 otherwise.
- R4: A read of offset 0x4 returns the pin levels as sampled by a two-flop synchroniser, including pins the port is driving itself. Every read's data appears on bus_rdata in the cycle after the bus_rd cycle.
- R5: A read of offset 0x6 returns the value last written to it.
- R6: After reset, the select, direction and pull-up registers (offsets 0x0, 0x2, 0x8) read 0, so pad_oe and pad_pu are 0.
- R7: Reset does not alter the output-data register.
- R8: pad_pu is 1 only for a pin in GPIO mode whose pull-up bit (offset 0x8) is 1 and whose direction bit is 0. It is always 0 for a peripheral pin.
- R9: With output data 0, setting the direction bit drives the pin low, and clearing it releases the pin, so that the pull-up can raise it.
- R10: Writes to offset 0x4 and to unmapped offsets change no register. Reads of any offset other than 0x0, 0x2, 0x4, 0x6 and 0x8 return 0.
- R11: per_in carries the synchronised pin level for peripheral pins and 0 for GPIO pins.
- R12: With NO_ALT = 1, offset 0x0 reads 0 and ignores writes, so every pin stays in GPIO mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Value to drive per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Weak pull-up enable per pin |
| pad_ie | output | 8 | Input-buffer enable per pin |
| per_out | input | 8 | Peripheral output value per pin |
| per_oe | input | 8 | Peripheral output enable per pin |
| per_in | output | 8 | Synchronised pin levels to the peripheral |

## Verification
The hardest situation to reach is a pin mix in which peripheral-owned, GPIO-driven, pulled-up-and-released and externally driven pins all sit in one byte. The pull-up gating, the output multiplexing and the input path all meet there. The stimulus sets the select, direction and pull-up registers to overlapping masks and drives per_oe to a mask that differs from the direction register. It then waits out the synchroniser before reading offset 0x4 and per_in against a bench pad model. Preservation of the output data through reset is reached by writing it, pulsing reset in the middle of the run and reading it back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFS_SEL  = 0;
  localparam int unsigned OFS_DIR  = 2;
  localparam int unsigned OFS_DIN  = 4;
  localparam int unsigned OFS_DOUT = 6;
  localparam int unsigned OFS_PU   = 8;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] s1_d, s2_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned W      = 8,
  parameter int unsigned AW     = 4,
  parameter bit          NO_ALT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pins,
  output logic [W-1:0]  sel_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  pu_q,
  output logic [W-1:0]  dout_q,
  output logic [W-1:0]  rdata,
  output logic          din_rd
);
  import gpio_pkg::*;

  logic hit_sel, hit_dir, hit_din, hit_dout, hit_pu;
  logic sel_we, dir_we, dout_we, pu_we, rd_en;
  logic [W-1:0] dir_d, pu_d, dout_d, rdata_d, rdata_q;

  always_comb begin
    hit_sel  = (addr == AW'(OFS_SEL));
    hit_dir  = (addr == AW'(OFS_DIR));
    hit_din  = (addr == AW'(OFS_DIN));
    hit_dout = (addr == AW'(OFS_DOUT));
    hit_pu   = (addr == AW'(OFS_PU));
    sel_we   = wr & hit_sel;
    dir_we   = wr & hit_dir;
    dout_we  = wr & hit_dout;
    pu_we    = wr & hit_pu;
    rd_en    = rd;
    din_rd   = rd & hit_din;
  end

  // selection register: present or tied to GPIO mode
  generate
    if (NO_ALT) begin : g_no_sel
      assign sel_q = '0;
    end else begin : g_sel
      logic [W-1:0] sel_r, sel_d;
      always_comb sel_d = sel_we ? wdata : sel_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_r <= '0;
        else        sel_r <= sel_d;
      end
      assign sel_q = sel_r;
    end
  endgenerate

  always_comb begin
    dir_d  = dir_we  ? wdata : dir_q;
    pu_d   = pu_we   ? wdata : pu_q;
    dout_d = dout_we ? wdata : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      pu_q  <= '0;
    end else begin
      dir_q <= dir_d;
      pu_q  <= pu_d;
    end
  end

  // output data survives reset
  always_ff @(posedge clk) begin
    if (dout_we) dout_q <= dout_d;
  end

  always_comb begin
    rdata_d = '0;
    if (hit_sel)  rdata_d = sel_q;
    if (hit_dir)  rdata_d = dir_q;
    if (hit_din)  rdata_d = pins;
    if (hit_dout) rdata_d = dout_q;
    if (hit_pu)   rdata_d = pu_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic sel,
  input  logic dir,
  input  logic dout,
  input  logic pu,
  input  logic p_out,
  input  logic p_oe,
  input  logic din_rd,
  output logic o_val,
  output logic o_en,
  output logic o_pu,
  output logic o_ie
);
  always_comb begin
    o_en  = sel ? p_oe  : dir;
    o_val = sel ? p_out : dout;
    o_pu  = ~sel & pu & ~dir;
    o_ie  = sel | din_rd;
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int unsigned W      = 8,
  parameter int unsigned AW     = 4,
  parameter bit          NO_ALT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu,
  output logic [W-1:0]  pad_ie,
  input  logic [W-1:0]  per_out,
  input  logic [W-1:0]  per_oe,
  output logic [W-1:0]  per_in
);
  logic          srst_n;
  logic [W-1:0]  pins_s;
  logic [W-1:0]  sel_w, dir_w, pu_w, dout_w;
  logic          din_rd;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gpio_in_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (pad_in),
    .q     (pins_s)
  );

  gpio_regs #(.W(W), .AW(AW), .NO_ALT(NO_ALT)) u_regs (
    .clk    (clk),
    .rst_n  (srst_n),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wdata  (bus_wdata),
    .pins   (pins_s),
    .sel_q  (sel_w),
    .dir_q  (dir_w),
    .pu_q   (pu_w),
    .dout_q (dout_w),
    .rdata  (bus_rdata),
    .din_rd (din_rd)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      gpio_pin_cell u_cell (
        .sel    (sel_w[i]),
        .dir    (dir_w[i]),
        .dout   (dout_w[i]),
        .pu     (pu_w[i]),
        .p_out  (per_out[i]),
        .p_oe   (per_oe[i]),
        .din_rd (din_rd),
        .o_val  (pad_out[i]),
        .o_en   (pad_oe[i]),
        .o_pu   (pad_pu[i]),
        .o_ie   (pad_ie[i])
      );
    end
  endgenerate

  assign per_in = pins_s & sel_w;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  sel_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  per_oe,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_pu,
  input logic [W-1:0]  pad_ie,
  input logic [W-1:0]  per_in
);
  import gpio_pkg::*;

  logic mapped;
  assign mapped = (bus_addr == AW'(OFS_SEL)) || (bus_addr == AW'(OFS_DIR)) ||
                  (bus_addr == AW'(OFS_DIN)) || (bus_addr == AW'(OFS_DOUT)) ||
                  (bus_addr == AW'(OFS_PU));

  p_oe_periph_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ per_oe) & sel_q) == '0);

  p_oe_gpio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & ~sel_q) == '0);

  p_ie_periph_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_ie & sel_q) == sel_q);

  p_ie_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == AW'(OFS_DIN)) |-> (pad_ie & ~sel_q) == '0);

  p_pu_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & (sel_q | dir_q)) == '0);

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> bus_rdata == '0);

  p_per_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (per_in & ~sel_q) == '0);
endmodule

bind gpio_mux_port gpio_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .sel_q     (sel_w),
  .dir_q     (dir_w),
  .per_oe    (per_oe),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu),
  .pad_ie    (pad_ie),
  .per_in    (per_in)
);

// File: tb/sim_gpio_mux_port.sv
`timescale 1ns/1ps
module sim_gpio_mux_port;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] b_addr = '0;
  logic b_wr = 1'b0, b_rd = 1'b0;
  logic [7:0] b_wdata = '0;
  logic [7:0] per_out = '0, per_oe = '0, ext = '0;

  logic [7:0] rdata0, pout0, poe0, ppu0, pie0, pin0, pins0;
  logic [7:0] rdata1, pout1, poe1, ppu1, pie1, pin1, pins1;

  int checks = 0, errors = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  // shadow state for the expected-value model
  logic [7:0] s_sel = 0, s_dir = 0, s_dout = 0, s_pu = 0;

  always #10 clk = ~clk;

  // pad model
  always_comb begin
    for (int i = 0; i < W; i++) begin
      pins0[i] = poe0[i] ? pout0[i] : (ppu0[i] ? 1'b1 : ext[i]);
      pins1[i] = poe1[i] ? pout1[i] : (ppu1[i] ? 1'b1 : ext[i]);
    end
  end

  gpio_mux_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(rdata0), .pad_in(pins0), .pad_out(pout0),
    .pad_oe(poe0), .pad_pu(ppu0), .pad_ie(pie0), .per_out(per_out),
    .per_oe(per_oe), .per_in(pin0));

  gpio_mux_port #(.NO_ALT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(rdata1), .pad_in(pins1), .pad_out(pout1),
    .pad_oe(poe1), .pad_pu(ppu1), .pad_ie(pie1), .per_out(per_out),
    .per_oe(per_oe), .per_in(pin1));

  function automatic logic [7:0] model_pins();
    logic [7:0] r;
    for (int i = 0; i < W; i++) begin
      logic oe, o, pu;
      oe = s_sel[i] ? per_oe[i] : s_dir[i];
      o  = s_sel[i] ? per_out[i] : s_dout[i];
      pu = !s_sel[i] && s_pu[i] && !s_dir[i];
      r[i] = oe ? o : (pu ? 1'b1 : ext[i]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_d <= b_rd;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata0, e);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk);
    b_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    b_addr = a; b_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    b_rd = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    s_sel = 0; s_dir = 0; s_pu = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R6 reset state
    #1;
    check("R6 pad_oe", poe0, 8'h00);
    check("R6 pad_pu", ppu0, 8'h00);
    rd(4'h0, 8'h00, "R6 sel");
    rd(4'h2, 8'h00, "R6 dir");
    rd(4'h8, 8'h00, "R6 pu");

    // R5 output data readback
    wr(4'h6, 8'h5A); s_dout = 8'h5A;
    rd(4'h6, 8'h5A, "R5 dout");

    // R2 GPIO drive
    wr(4'h2, 8'hFF); s_dir = 8'hFF;
    check("R2 oe", poe0, 8'hFF);
    check("R2 out", pout0, 8'h5A);
    check("R3 ie idle", pie0, 8'h00);

    // R4 read back pins being driven
    ext = 8'hC3;
    idle(3);
    rd(4'h4, model_pins(), "R4 din driven");
    wr(4'h2, 8'h0F); s_dir = 8'h0F;
    idle(3);
    rd(4'h4, model_pins(), "R4 din mixed");

    // R3 input enable during data-input read
    @(negedge clk);
    b_addr = 4'h4; b_rd = 1'b1;
    exp_q.push_back(model_pins()); tag_q.push_back("R4 din again");
    #1 check("R3 ie read", pie0, 8'hFF);
    @(negedge clk);
    b_rd = 1'b0;
    #1 check("R3 ie after", pie0, 8'h00);

    // R8 pull-up gating
    wr(4'h8, 8'hFF); s_pu = 8'hFF;
    check("R8 pu gpio", ppu0, 8'hF0);
    per_out = 8'hFF; per_oe = 8'h20;
    wr(4'h0, 8'h30); s_sel = 8'h30;
    check("R8 pu periph", ppu0, 8'hC0);

    // R1 per-pin selection
    check("R1 oe", poe0, 8'h2F);
    check("R1 out", pout0, 8'h7A);
    check("R3 ie periph", pie0, 8'h30);
    rd(4'h0, 8'h30, "R1 sel readback");

    // R11 peripheral input path
    idle(3);
    check("R11 per_in", pin0, model_pins() & 8'h30);
    rd(4'h4, model_pins(), "R4 din periph mix");

    // R9 open drain on pin 0
    wr(4'h0, 8'h00); s_sel = 8'h00;
    wr(4'h6, 8'h00); s_dout = 8'h00;
    wr(4'h2, 8'h01); s_dir = 8'h01;
    check("R9 oe low", poe0 & 8'h01, 8'h01);
    check("R9 out low", pout0 & 8'h01, 8'h00);
    idle(3);
    rd(4'h4, model_pins(), "R9 pin low");
    wr(4'h2, 8'h00); s_dir = 8'h00;
    check("R9 released", poe0 & 8'h01, 8'h00);
    check("R9 pull", ppu0 & 8'h01, 8'h01);
    idle(3);
    rd(4'h4, model_pins(), "R9 pin pulled");

    // R10 map holes and read-only input register
    wr(4'h4, 8'h00);
    wr(4'h3, 8'hFF);
    rd(4'h2, 8'h00, "R10 dir untouched");
    rd(4'h8, 8'hFF, "R10 pu untouched");
    rd(4'h4, model_pins(), "R10 din ro");
    rd(4'h1, 8'h00, "R10 hole 1");
    rd(4'hA, 8'h00, "R10 hole A");
    rd(4'hF, 8'h00, "R10 hole F");

    // R7 output data survives reset
    wr(4'h6, 8'hA5); s_dout = 8'hA5;
    do_reset();
    rd(4'h6, 8'hA5, "R7 dout kept");
    rd(4'h0, 8'h00, "R6 sel after reset");

    // R12 variant without selection register
    per_oe = 8'hFF;
    wr(4'h0, 8'hFF); s_sel = 8'hFF;
    wr(4'h2, 8'h00);
    @(negedge clk);
    b_addr = 4'h0; b_rd = 1'b1;
    exp_q.push_back(8'hFF); tag_q.push_back("R1 sel set");
    @(negedge clk);
    b_rd = 1'b0;
    #1 check("R12 sel reads 0", rdata1, 8'h00);
    check("R12 oe ignores periph", poe1, 8'h00);
    check("R12 ie idle", pie1, 8'h00);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule